// File: doc/BRIEF.md
# PHY Interrupt Mask and Status Unit

This block turns event indications from an Ethernet transceiver into a single active-low interrupt line. Every event has a bit in a sticky status register. A companion mask register selects which recorded events may pull the interrupt line low. A management register port reads and writes both registers. Reading the status register returns the recorded events and clears them in the same operation.

Two of the events arrive as levels: link state and receive descrambler lock. The block turns each change of these levels, in either direction, into an event. A small symbol-stream detector inside the block raises the premature-end event. It does so when a run of IDLE symbols appears inside a 100BASE-TX frame before the end-of-stream delimiter.

A compatibility-mode input locks the four most significant mask bits. While it is set, those bits read as zero, ignore writes and cannot drive the interrupt. Their stored values come back when the mode is cleared. The events themselves are still recorded in the status register.

Top module: `phy_irq_unit`

## Requirements
- R1: After synchronous reset the mask reads 8000h, the status reads 0000h and `irq_n_o` is high.
- R2: A write to address 10h stores bits 15:4 into the mask. Mask bits 3:0 are reserved: they read 0 and ignore writes. A read of 10h returns the mask.
- R3: Status is read at address 11h. `mgmt_rdata_o` is valid from the clock edge that samples `mgmt_rd_i`. Status bits are sticky until read. A read clears the status. Writes to 11h have no effect. Any other address reads 0000h.
- R4: An event in the same cycle as a status read is not in that read's data. It stays set and is returned by the next read.
- R5: `irq_n_o` is registered. It is low exactly when the status ANDed with the effective mask is nonzero. A masked event is still recorded in the status register.
- R6: While `compat_i` is 1, mask bits 15:12 read 0, ignore writes and are treated as 0 for the interrupt. Their stored values reappear when `compat_i` returns to 0.
- R7: Each change of `link_up_i` sets status bit 14. Each change of `lock_i` sets status bit 13. Both directions count. Both levels are taken as 0 at reset.
- R8: Symbol codes are 0 DATA, 1 IDLE, 2 SSD (start of stream) and 3 ESD (end of stream). SSD arms the detector and ESD disarms it. A DATA symbol restarts the IDLE count. Two consecutive valid IDLE symbols while armed set status bit 12 one cycle after the second IDLE. At most one event is raised per armed frame.
- R9: Bit map: 15 link unstable (`unstable_i`), 14 link change, 13 lock change, 12 premature end, 11:4 = `misc_evt_i[7:0]` (jabber, auto-negotiation done, parallel-detect fault, remote fault, loopback, three counter rollovers).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| compat_i | input | 1 | Compatibility mode; locks mask bits 15:12 |
| link_up_i | input | 1 | Link state level |
| lock_i | input | 1 | Descrambler lock level |
| unstable_i | input | 1 | Link-unstable event pulse |
| misc_evt_i | input | 8 | Event pulses for status bits 11:4 |
| sym_valid_i | input | 1 | Symbol strobe |
| sym_code_i | input | 2 | Symbol class code |
| mgmt_addr_i | input | 5 | Register address |
| mgmt_wr_i | input | 1 | Write strobe |
| mgmt_rd_i | input | 1 | Read strobe |
| mgmt_wdata_i | input | 16 | Write data |
| mgmt_rdata_o | output | 16 | Registered read data |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The bench places events in the same cycle as status reads. A design that cleared after the merge would drop those events, and the following read would come back empty.

It writes the mask while compatibility mode is active and then leaves the mode. A design that let the write through would return zeros in the locked bits instead of the saved value.

It drives IDLE runs broken by DATA, runs that follow ESD, and back-to-back IDLEs inside armed frames. A detector that counted non-consecutive IDLEs or stayed armed after ESD would raise false premature-end events. It also toggles the link and lock levels in both directions, so a detector of only rising edges misses half the changes.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    SYM_DATA = 2'd0,
    SYM_IDLE = 2'd1,
    SYM_SSD  = 2'd2,
    SYM_ESD  = 2'd3
  } sym_e;

  localparam int BIT_UNSTABLE = 15;
  localparam int BIT_LINK     = 14;
  localparam int BIT_LOCK     = 13;
  localparam int BIT_PEND     = 12;
  localparam int MISC_LSB     = 4;
  localparam int MISC_N       = 8;

  localparam logic [REG_W-1:0] IMPL_BITS = 16'hFFF0;
  localparam logic [REG_W-1:0] LOCK_BITS = 16'hF000;
  localparam logic [REG_W-1:0] MASK_RST  = 16'h8000;
endpackage

// File: rtl/phy_irq_levelchg.sv
module phy_irq_levelchg #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= '0;
    else       prev_q <= lvl_i;
  end

  assign chg_o = rst_i ? '0 : (lvl_i ^ prev_q);
endmodule

// File: rtl/phy_irq_pend_det.sv
module phy_irq_pend_det
  import phy_irq_pkg::*;
#(
  parameter int IDLE_RUN = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       sym_valid_i,
  input  logic [1:0] sym_code_i,
  output logic       pend_o
);
  localparam int CW = $clog2(IDLE_RUN + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_RUN - 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= 1'b0;
      if (sym_valid_i) begin
        case (sym_e'(sym_code_i))
          SYM_SSD: begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
          end
          SYM_ESD: begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
          end
          SYM_IDLE: begin
            if (armed_q) begin
              if (cnt_q == LAST) begin
                pend_q  <= 1'b1;
                armed_q <= 1'b0;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: cnt_q <= '0;
        endcase
      end
    end
  end

  assign pend_o = pend_q;

  // R8
  pend_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pend_q |=> !pend_q);
endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
  import phy_irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 5'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h11
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              compat_i,
  input  logic [REG_W-1:0]  evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_n_o
);
  logic [REG_W-1:0] mask_q, mask_d, stat_q, stat_d;
  logic [REG_W-1:0] lock_m, mask_view, eff_mask, evt_m, rdata_q;
  logic             irq_n_q;
  logic             mask_wr, stat_rd;

  assign mask_wr   = wr_i && (addr_i == MASK_ADDR);
  assign stat_rd   = rd_i && (addr_i == STAT_ADDR);
  assign lock_m    = compat_i ? LOCK_BITS : '0;
  assign mask_view = mask_q & IMPL_BITS & ~lock_m;
  assign evt_m     = evt_i & IMPL_BITS;

  always_comb begin
    mask_d = mask_q;
    if (mask_wr)
      mask_d = (wdata_i & IMPL_BITS & ~lock_m) | (mask_q & lock_m);
  end

  assign stat_d   = (stat_rd ? '0 : stat_q) | evt_m;
  assign eff_mask = mask_d & IMPL_BITS & ~lock_m;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mask_q  <= MASK_RST;
      stat_q  <= '0;
      irq_n_q <= 1'b1;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d;
      stat_q  <= stat_d;
      irq_n_q <= ~|(stat_d & eff_mask);
      if (rd_i) begin
        if (addr_i == MASK_ADDR)      rdata_q <= mask_view;
        else if (addr_i == STAT_ADDR) rdata_q <= stat_q;
        else                          rdata_q <= '0;
      end
    end
  end

  assign rdata_o = rdata_q;
  assign irq_n_o = irq_n_q;

  // R6
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!rst_i && compat_i && mask_wr) |-> (mask_q[15:12] == $past(mask_q[15:12])));
  // R3
  sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!rst_i && !stat_rd) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R4
  no_loss_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!rst_i) |-> ((stat_q & $past(evt_m)) == $past(evt_m)));
  // R5
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (stat_q == '0) |-> irq_n_o);
  // R2
  resv_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rdata_o[3:0] == 4'h0);
endmodule

// File: rtl/phy_irq_unit.sv
module phy_irq_unit
  import phy_irq_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int IDLE_RUN = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              compat_i,
  input  logic              link_up_i,
  input  logic              lock_i,
  input  logic              unstable_i,
  input  logic [7:0]        misc_evt_i,
  input  logic              sym_valid_i,
  input  logic [1:0]        sym_code_i,
  input  logic [ADDR_W-1:0] mgmt_addr_i,
  input  logic              mgmt_wr_i,
  input  logic              mgmt_rd_i,
  input  logic [15:0]       mgmt_wdata_i,
  output logic [15:0]       mgmt_rdata_o,
  output logic              irq_n_o
);
  logic [1:0]       chg;
  logic             pend;
  logic [REG_W-1:0] evt;

  phy_irq_levelchg #(.W(2)) u_chg (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .lvl_i ({link_up_i, lock_i}),
    .chg_o (chg)
  );

  phy_irq_pend_det #(.IDLE_RUN(IDLE_RUN)) u_pend (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .sym_valid_i (sym_valid_i),
    .sym_code_i  (sym_code_i),
    .pend_o      (pend)
  );

  always_comb begin
    evt = '0;
    evt[BIT_UNSTABLE] = unstable_i;
    evt[BIT_LINK]     = chg[1];
    evt[BIT_LOCK]     = chg[0];
    evt[BIT_PEND]     = pend;
    evt[MISC_LSB +: MISC_N] = misc_evt_i;
  end

  phy_irq_regs #(
    .ADDR_W    (ADDR_W),
    .MASK_ADDR (ADDR_W'(5'h10)),
    .STAT_ADDR (ADDR_W'(5'h11))
  ) u_regs (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .compat_i(compat_i),
    .evt_i   (evt),
    .addr_i  (mgmt_addr_i),
    .wr_i    (mgmt_wr_i),
    .rd_i    (mgmt_rd_i),
    .wdata_i (mgmt_wdata_i),
    .rdata_o (mgmt_rdata_o),
    .irq_n_o (irq_n_o)
  );
endmodule

// File: tb/phy_irq_unit_tb_top.sv
`timescale 1ns/1ps
module phy_irq_unit_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic compat, link_up, lock, unstable, sym_valid, wr, rd;
  logic [7:0]  misc;
  logic [1:0]  sym;
  logic [4:0]  addr;
  logic [15:0] wdata, rdata;
  logic        irq_n;

  int n_chk = 0, n_fail = 0;
  string cur_tag = "";

  // model state
  logic [15:0] m_mask, m_stat;
  logic m_link, m_lock, m_pend, m_armed;
  int   m_cnt;

  always #2.5 clk = ~clk;

  phy_irq_unit dut_i (
    .clk_i(clk), .rst_i(rst), .compat_i(compat), .link_up_i(link_up),
    .lock_i(lock), .unstable_i(unstable), .misc_evt_i(misc),
    .sym_valid_i(sym_valid), .sym_code_i(sym), .mgmt_addr_i(addr),
    .mgmt_wr_i(wr), .mgmt_rd_i(rd), .mgmt_wdata_i(wdata),
    .mgmt_rdata_o(rdata), .irq_n_o(irq_n)
  );

  function automatic logic [15:0] view(input logic [15:0] m, input logic c);
    return m & 16'hFFF0 & (c ? 16'h0FFF : 16'hFFFF);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mask = 16'h8000; m_stat = 16'h0; m_link = 0; m_lock = 0;
    m_pend = 0; m_armed = 0; m_cnt = 0;
  endtask

  task automatic idle_inputs();
    wr = 0; rd = 0; unstable = 0; misc = '0; sym_valid = 0; sym = 0;
    addr = 0; wdata = 0;
  endtask

  // one cycle: inputs already set at negedge
  task automatic step();
    logic [15:0] ev, exp_rd;
    @(posedge clk); #1;
    ev = '0;
    ev[15] = unstable;
    ev[14] = link_up ^ m_link;
    ev[13] = lock ^ m_lock;
    ev[12] = m_pend;
    ev[11:4] = misc;
    exp_rd = 16'h0;
    if (addr == 5'h10) exp_rd = view(m_mask, compat);
    else if (addr == 5'h11) exp_rd = m_stat;
    m_stat = ((rd && addr == 5'h11) ? 16'h0 : m_stat) | ev;
    if (wr && addr == 5'h10) begin
      if (compat) m_mask = (wdata & 16'h0FF0) | (m_mask & 16'hF000);
      else        m_mask = wdata & 16'hFFF0;
    end
    m_link = link_up; m_lock = lock;
    // detector
    m_pend = 0;
    if (sym_valid) begin
      case (sym)
        2'd2: begin m_armed = 1; m_cnt = 0; end
        2'd3: begin m_armed = 0; m_cnt = 0; end
        2'd1: if (m_armed) begin
                if (m_cnt + 1 == 2) begin m_pend = 1; m_armed = 0; m_cnt = 0; end
                else m_cnt++;
              end
        default: m_cnt = 0;
      endcase
    end
    if (rd) check(cur_tag == "" ? (addr == 5'h10 ? "R2 mask read" : "R3 status read") : cur_tag,
                  rdata, exp_rd);
    check("R5 irq", {15'h0, irq_n}, {15'h0, ~|(m_stat & view(m_mask, compat))});
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_read(input logic [4:0] a);
    addr = a; rd = 1; step();
  endtask

  task automatic do_write(input logic [4:0] a, input logic [15:0] d);
    addr = a; wr = 1; wdata = d; step();
  endtask

  task automatic send_sym(input logic [1:0] s);
    sym_valid = 1; sym = s; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd5171));
    rst = 1; compat = 0; link_up = 0; lock = 0; idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; model_reset();
    check("R1 irq_n after reset", {15'h0, irq_n}, 16'h1);
    cur_tag = "R1 reset mask"; do_read(5'h10);
    cur_tag = "R1 reset status"; do_read(5'h11);

    cur_tag = "R2 reserved bits"; do_write(5'h10, 16'hFFFF); do_read(5'h10);
    cur_tag = "R3 unused address"; do_read(5'h05);

    cur_tag = "R9 misc bit0 -> status bit 4"; misc = 8'h01; step(); do_read(5'h11);
    cur_tag = "R3 cleared after read"; do_read(5'h11);
    cur_tag = "R3 write to status ignored"; misc = 8'h80; step();
    do_write(5'h11, 16'h0000); do_read(5'h11);

    cur_tag = "R4 event during read"; addr = 5'h11; rd = 1; unstable = 1; step();
    cur_tag = "R4 event kept for next read"; do_read(5'h11);

    cur_tag = "R5 masked event recorded"; do_write(5'h10, 16'h0000);
    misc = 8'h04; step(); do_read(5'h11);

    cur_tag = "R6 locked bits"; do_write(5'h10, 16'hF0F0);
    compat = 1; step(); do_read(5'h10);
    do_write(5'h10, 16'h0000); unstable = 1; step(); do_read(5'h10);
    compat = 0; step(); cur_tag = "R6 restored"; do_read(5'h10); do_read(5'h11);

    cur_tag = "R7 link up"; link_up = 1; step(); do_read(5'h11);
    cur_tag = "R7 link down"; link_up = 0; step(); do_read(5'h11);
    cur_tag = "R7 lock both ways"; lock = 1; step(); lock = 0; step(); do_read(5'h11);

    cur_tag = "R8 premature end";
    send_sym(2'd2); send_sym(2'd0); send_sym(2'd1); send_sym(2'd1); step(); do_read(5'h11);
    cur_tag = "R8 broken run / after ESD";
    send_sym(2'd2); send_sym(2'd1); send_sym(2'd0); send_sym(2'd1); send_sym(2'd3);
    send_sym(2'd1); send_sym(2'd1); step(); do_read(5'h11);
    cur_tag = "R8 one per frame";
    send_sym(2'd2); send_sym(2'd1); send_sym(2'd1); send_sym(2'd1); send_sym(2'd1);
    step(); do_read(5'h11);

    cur_tag = "";
    for (int i = 0; i < 4000; i++) begin
      int r;
      if (($urandom % 64) == 0) compat = ~compat;
      if (($urandom % 20) == 0) link_up = ~link_up;
      if (($urandom % 20) == 0) lock = ~lock;
      unstable = (($urandom % 30) == 0);
      misc = 8'($urandom & $urandom & $urandom);
      sym_valid = $urandom % 2;
      r = $urandom % 8;
      sym = (r < 4) ? 2'd1 : (r < 6) ? 2'd0 : (r == 6) ? 2'd2 : 2'd3;
      r = $urandom % 16;
      if (r < 2) begin
        rd = 1; addr = (r == 0) ? 5'h10 : 5'h11;
      end else if (r == 2) begin
        rd = 1; addr = 5'h11;
      end else if (r == 3) begin
        wr = 1; addr = ($urandom % 4 == 0) ? 5'h11 : 5'h10; wdata = 16'($urandom);
      end
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule